// File: doc/BRIEF.md
# Privileged Instruction and Port Access Gate

This block decides whether an instruction may go ahead. A request strobe carries four things: an instruction class code, the current privilege level, the I/O privilege level and a 16-bit port number. One cycle later the block answers with an allow flag or with a fault cause. Privilege levels run from 0 to 3, and 0 is the most privileged.

Some instructions can disturb the whole machine: halt, the loads of the control, debug and descriptor-table base registers. These are allowed only at level 0. The interrupt enable and disable instructions are checked against the I/O privilege level. A port access is checked against an internal map that holds one bit for each of the 65536 ports. A set bit marks the port as protected. A host fills this map one 32-bit word at a time.

All classes answer with the same latency of one cycle, so the caller can issue one request in every cycle.

Top module: `priv_io_gate`

## Requirements
- R1: After reset, and in every cycle whose response is not valid, `rsp_valid`, `rsp_allow` and `rsp_cause` are all 0.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle in which `req_valid` is 1. Requests in consecutive cycles each receive their own response.
- R3: The classes halt (1), control-register load (2), debug-register load (3) and table-base load (4) are allowed when `cur_lvl` is 0. At any other level they are refused with cause 1 (privileged instruction).
- R4: The classes interrupt enable (5) and interrupt disable (6) are refused with cause 2 (interrupt flag) when `cur_lvl` is numerically greater than `io_lvl`. Otherwise they are allowed.
- R5: Class 7 (port access) is refused with cause 3 (port protected) when the map bit for `port_num` is 1. It is allowed when that bit is 0, whatever the two levels are.
- R6: Class 0 (all other instructions) is always allowed. An allowed response has `rsp_allow`=1 and `rsp_cause`=0.
- R7: A write with `map_we`=1 stores `map_wdata` into word `map_waddr`. Bit b of word w governs port w*32+b.
- R8: A lookup issued in the same cycle as a write to its word sees the map bit from before the write. A lookup issued in the cycle after the write sees the new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_class | input | 3 | Instruction class code |
| cur_lvl | input | 2 | Current privilege level |
| io_lvl | input | 2 | I/O privilege level |
| port_num | input | 16 | Port addressed by a port access |
| map_we | input | 1 | Map word write enable |
| map_waddr | input | 11 | Map word index |
| map_wdata | input | 32 | Map word data |
| rsp_valid | output | 1 | Response valid |
| rsp_allow | output | 1 | Instruction may proceed |
| rsp_cause | output | 2 | Fault cause: 0 none, 1 privileged, 2 interrupt flag, 3 port |

## Verification
A host write to the map and a port lookup that uses the same map word can arrive in the same cycle. The bench provokes this by driving a write that sets a port's bit together with a port access to that port. It then repeats the same access in the next cycle. The first response must allow the access, because it sees the old bit, and the second must refuse it with cause 3. Back-to-back requests of mixed classes are also applied, to show that one response cannot leak into the next.

// File: rtl/pio_gate_pkg.sv
package pio_gate_pkg;

    typedef enum logic [2:0] {
        CLS_OTHER   = 3'd0,
        CLS_HALT    = 3'd1,
        CLS_LD_CTRL = 3'd2,
        CLS_LD_DBG  = 3'd3,
        CLS_LD_TBL  = 3'd4,
        CLS_INT_EN  = 3'd5,
        CLS_INT_DIS = 3'd6,
        CLS_PORT    = 3'd7
    } insn_cls_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_PRIV = 2'd1,
        CAUSE_IFLG = 2'd2,
        CAUSE_PORT = 2'd3
    } fault_cause_e;

endpackage

// File: rtl/pio_level_check.sv
module pio_level_check
    import pio_gate_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic [2:0]       cls,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic [LVL_W-1:0] io_lvl,
    output logic             fault,
    output logic [1:0]       cause
);

    always_comb begin
        fault = 1'b0;
        cause = CAUSE_NONE;
        case (cls)
            CLS_HALT, CLS_LD_CTRL, CLS_LD_DBG, CLS_LD_TBL: begin
                fault = (cur_lvl != '0);
                cause = CAUSE_PRIV;
            end
            CLS_INT_EN, CLS_INT_DIS: begin
                fault = (cur_lvl > io_lvl);
                cause = CAUSE_IFLG;
            end
            default: begin
                fault = 1'b0;
                cause = CAUSE_NONE;
            end
        endcase
    end

endmodule

// File: rtl/pio_bitmap_ram.sv
module pio_bitmap_ram #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/priv_io_gate.sv
module priv_io_gate
    import pio_gate_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int WORD_W = 32,
    parameter int LVL_W  = 2,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int ADDR_W = PORT_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_class,
    input  logic [LVL_W-1:0]  cur_lvl,
    input  logic [LVL_W-1:0]  io_lvl,
    input  logic [PORT_W-1:0] port_num,
    input  logic              map_we,
    input  logic [ADDR_W-1:0] map_waddr,
    input  logic [WORD_W-1:0] map_wdata,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic [1:0]        rsp_cause
);

    typedef struct packed {
        logic             vld;
        logic             lvl_flt;
        logic [1:0]       lvl_cause;
        logic             is_port;
        logic [BIT_W-1:0] bit_sel;
    } stage_t;

    stage_t stg_d, stg_q;

    logic              chk_fault;
    logic [1:0]        chk_cause;
    logic [WORD_W-1:0] map_word;
    logic              port_prot;

    pio_level_check #(.LVL_W(LVL_W)) u_lvl (
        .cls     (req_class),
        .cur_lvl (cur_lvl),
        .io_lvl  (io_lvl),
        .fault   (chk_fault),
        .cause   (chk_cause)
    );

    pio_bitmap_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .waddr (map_waddr),
        .wdata (map_wdata),
        .re    (req_valid),
        .raddr (port_num[PORT_W-1:BIT_W]),
        .rdata (map_word)
    );

    always_comb begin
        stg_d           = stg_q;
        stg_d.vld       = req_valid;
        stg_d.lvl_flt   = req_valid & chk_fault;
        stg_d.lvl_cause = chk_cause;
        stg_d.is_port   = req_valid & (req_class == CLS_PORT);
        stg_d.bit_sel   = port_num[BIT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    always_comb begin
        port_prot = stg_q.is_port & map_word[stg_q.bit_sel];
        rsp_valid = stg_q.vld;
        rsp_allow = stg_q.vld & ~stg_q.lvl_flt & ~port_prot;
        if (!stg_q.vld) begin
            rsp_cause = CAUSE_NONE;
        end else if (stg_q.lvl_flt) begin
            rsp_cause = stg_q.lvl_cause;
        end else if (port_prot) begin
            rsp_cause = CAUSE_PORT;
        end else begin
            rsp_cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/pio_gate_chk.sv
module pio_gate_chk
    import pio_gate_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_class,
    input logic [1:0] cur_lvl,
    input logic [1:0] io_lvl,
    input logic       rsp_valid,
    input logic       rsp_allow,
    input logic [1:0] rsp_cause
);

    // R1
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && rsp_cause == 2'd0));

    // R2
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    a_r3_priv_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class >= 3'd1 && req_class <= 3'd4 && cur_lvl != 2'd0)
        |=> (!rsp_allow && rsp_cause == 2'd1));

    a_r3_priv_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class >= 3'd1 && req_class <= 3'd4 && cur_lvl == 2'd0)
        |=> (rsp_allow && rsp_cause == 2'd0));

    // R4
    a_r4_iflag_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_class == 3'd5 || req_class == 3'd6) && cur_lvl > io_lvl)
        |=> (!rsp_allow && rsp_cause == 2'd2));

    a_r4_iflag_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_class == 3'd5 || req_class == 3'd6) && cur_lvl <= io_lvl)
        |=> rsp_allow);

    // R5: a port access can only be refused for the port reason
    a_r5_port_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 3'd7)
        |=> (rsp_allow ? rsp_cause == 2'd0 : rsp_cause == 2'd3));

    // R6
    a_r6_other_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 3'd0) |=> (rsp_allow && rsp_cause == 2'd0));

endmodule

bind priv_io_gate pio_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_class (req_class),
    .cur_lvl   (cur_lvl),
    .io_lvl    (io_lvl),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow),
    .rsp_cause (rsp_cause)
);

// File: tb/tb_priv_io_gate.sv
`timescale 1ns/1ps
module tb_priv_io_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_class = '0;
    logic [1:0]  cur_lvl = '0;
    logic [1:0]  io_lvl = '0;
    logic [15:0] port_num = '0;
    logic        map_we = 1'b0;
    logic [10:0] map_waddr = '0;
    logic [31:0] map_wdata = '0;
    logic        rsp_valid, rsp_allow;
    logic [1:0]  rsp_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    priv_io_gate dut (.*);

    task automatic chk(input string tag, input logic v, input logic a, input logic [1:0] c);
        n_chk++;
        if (rsp_valid !== v || rsp_allow !== a || rsp_cause !== c) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b allow=%0b cause=%0d, expected valid=%0b allow=%0b cause=%0d",
                     tag, rsp_valid, rsp_allow, rsp_cause, v, a, c);
        end
    endtask

    function automatic logic [1:0] model(input logic [2:0] cls, input logic [1:0] cl,
                                         input logic [1:0] il, input logic pbit);
        if (cls >= 3'd1 && cls <= 3'd4) return (cl != 0) ? 2'd1 : 2'd0;
        if (cls == 3'd5 || cls == 3'd6) return (cl > il) ? 2'd2 : 2'd0;
        if (cls == 3'd7) return pbit ? 2'd3 : 2'd0;
        return 2'd0;
    endfunction

    task automatic drive(input logic [2:0] cls, input logic [1:0] cl, input logic [1:0] il,
                         input logic [15:0] p);
        req_valid = 1'b1; req_class = cls; cur_lvl = cl; io_lvl = il; port_num = p;
    endtask

    task automatic one(input string tag, input logic [2:0] cls, input logic [1:0] cl,
                       input logic [1:0] il, input logic [15:0] p, input logic pbit);
        logic [1:0] c;
        @(negedge clk);
        drive(cls, cl, il, p);
        @(negedge clk);
        req_valid = 1'b0;
        c = model(cls, cl, il, pbit);
        chk(tag, 1'b1, c == 2'd0, c);
    endtask

    task automatic map_write(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        map_we = 1'b1; map_waddr = a; map_wdata = d;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_priv;
        for (int cls = 1; cls <= 4; cls++)
            for (int l = 0; l < 4; l++)
                one("R3 privileged class", 3'(cls), 2'(l), 2'd3, 16'h0, 1'b0);
    endtask

    task automatic t_iflag;
        for (int cls = 5; cls <= 6; cls++)
            for (int l = 0; l < 4; l++)
                for (int i = 0; i < 4; i++)
                    one("R4 interrupt flag", 3'(cls), 2'(l), 2'(i), 16'h0, 1'b0);
    endtask

    task automatic t_port;
        map_write(11'd0, 32'h8000_0001);
        map_write(11'd2047, 32'h8000_0000);
        map_write(11'h091, 32'h0010_0000);
        one("R5 port 0", 3'd7, 2'd3, 2'd0, 16'd0, 1'b1);
        one("R7 port 31", 3'd7, 2'd0, 2'd3, 16'd31, 1'b1);
        one("R7 port 1", 3'd7, 2'd3, 2'd0, 16'd1, 1'b0);
        one("R7 port 32", 3'd7, 2'd3, 2'd0, 16'd32, 1'b0);
        one("R7 port 65535", 3'd7, 2'd0, 2'd0, 16'hFFFF, 1'b1);
        one("R7 port 65534", 3'd7, 2'd0, 2'd0, 16'hFFFE, 1'b0);
        one("R5 port 0x1234", 3'd7, 2'd2, 2'd1, 16'h1234, 1'b1);
        one("R5 port 0x1235", 3'd7, 2'd2, 2'd1, 16'h1235, 1'b0);
    endtask

    task automatic t_other;
        for (int l = 0; l < 4; l++)
            one("R6 other class", 3'd0, 2'(l), 2'd0, 16'd0, 1'b1);
    endtask

    task automatic t_b2b;
        @(negedge clk);
        drive(3'd1, 2'd2, 2'd0, 16'd0);
        @(negedge clk);
        chk("R2 b2b first", 1'b1, 1'b0, 2'd1);
        drive(3'd0, 2'd2, 2'd0, 16'd0);
        @(negedge clk);
        chk("R2 b2b second", 1'b1, 1'b1, 2'd0);
        drive(3'd7, 2'd0, 2'd0, 16'd0);
        @(negedge clk);
        chk("R2 b2b third", 1'b1, 1'b0, 2'd3);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 R2 idle after burst", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        map_we = 1'b1; map_waddr = 11'd100; map_wdata = 32'h0000_0100;
        drive(3'd7, 2'd0, 2'd0, 16'd3208);
        @(negedge clk);
        map_we = 1'b0;
        chk("R8 same-cycle old bit", 1'b1, 1'b1, 2'd0);
        @(negedge clk);
        chk("R8 next-cycle new bit", 1'b1, 1'b0, 2'd3);
        req_valid = 1'b0;
        map_write(11'd100, 32'h0);
        one("R7 cleared again", 3'd7, 2'd0, 2'd0, 16'd3208, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        for (int w = 0; w < 2048; w++) map_write(11'(w), 32'h0);
        t_priv();
        t_iflag();
        t_port();
        t_other();
        t_b2b();
        t_collide();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule